// File: doc/BRIEF.md
# Two-Wire Slave Memory Interface

This block is a two-wire serial slave that lets a bus master read and write a 256-byte space of registers and memory one byte at a time. It runs entirely on a fast system clock. The serial clock and data lines, and the write-protect input, pass through a synchronizer. START, STOP and the serial clock edges are then found as single-cycle events. The block drives the data line only as an open-drain pull-down enable.

A transfer opens with a control byte. The control byte carries a fixed four-bit code, a three-bit device select and a direction bit. Writes take an address byte and then up to eight data bytes. These bytes collect in a page buffer, and the buffer reaches memory only when the master closes the transfer with STOP. After a committing STOP, a write cycle of fixed length runs, and the slave ignores its own address until that cycle ends. A master can therefore poll for completion by watching for the acknowledge. Reads start at a persistent internal pointer. A random read is made by a dummy write of the address followed by a repeated START.

The device select comes from three strap pins or from a select register held in the memory space, chosen by an enable bit in that register.

Top module: `twi_mem_slave`

## Requirements
- R1: The control byte is received MSB first as code 4'b1010, then select bits [3:1], then direction in bit 0 (1 = read). If the code or the select does not match, the slave does not acknowledge and stays silent until the next START.
- R2: Data is sampled on rising serial clock edges. The slave changes its pull-down only while the serial clock is low. For every byte it accepts, it holds the data line low through the ninth clock.
- R3: A write carries one address byte and then data bytes for consecutive addresses, wrapping after FFh. At most 8 data bytes are buffered and acknowledged; the ninth and later bytes get no acknowledge and are not stored.
- R4: Buffered bytes are written only on STOP. A write cycle of WR_CYCLES system clocks then runs, and during it the control byte gets no acknowledge.
- R5: The pointer holds the last accessed address plus one and wraps from FFh to 00h. A read without an address byte starts at the pointer.
- R6: An address byte followed by a repeated START and a read control byte returns data starting at that address.
- R7: A START, repeated or not, discards any data bytes not yet committed by STOP.
- R8: While write-protect is high, data bytes get no acknowledge and memory keeps its contents.
- R9: During a read, the slave sends the next byte after each master acknowledge. After a master no-acknowledge it releases the data line.
- R10: The select register is at address FEh. Bit 0 set means the pins give the device select; with bit 0 clear and all pins low, bits [3:1] give it. Its reset value is 01h.
- R11: After reset the data line is released, the pointer is 00h, and every byte reads 00h except the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Write protect, high refuses writes |
| pin_sel_i | input | 3 | Strapped device select pins |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
The bench polls for the acknowledge right after a committing STOP. A design that acknowledged during the write cycle, or committed on the data acknowledge instead of on STOP, shows up here. It also abandons a write with a repeated START and reads the location back, which catches a buffer that leaks into memory without STOP. It runs a sequential read across FFh to catch a pointer that saturates or fails to wrap, and sends a ninth page byte to catch a buffer that overwrites its first entry. It also moves the device select between the register and the pins to catch a select source that ignores the enable bit or the all-low pin condition.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_MADDR, PH_WDATA, PH_RD, PH_SKIP} phase_t;

  localparam logic [3:0] CTRL_CODE = 4'b1010;

  // Device select in force: register bits when its enable bit is clear and all pins are low.
  function automatic logic [2:0] eff_select(input logic [2:0] pins, input logic [7:0] selreg);
    if (!selreg[0] && pins == 3'b000) return selreg[3:1];
    return pins;
  endfunction

  function automatic logic ctrl_hit(input logic [7:0] ctrl, input logic [2:0] sel);
    return (ctrl[7:4] == CTRL_CODE) && (ctrl[3:1] == sel);
  endfunction

  // Pull-down level for bit number idx (0 = MSB) of a byte being sent.
  function automatic logic tx_pull(input logic [7:0] b, input logic [3:0] idx);
    return ~b[3'(4'd7 - idx)];
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl_o  = s2;
  assign rise_o = s2 & ~s3;
  assign fall_o = ~s2 & s3;
endmodule

// File: rtl/twi_regfile.sv
`timescale 1ns/1ps
module twi_regfile #(
  parameter int AW = 8,
  parameter int SEL_ADDR = 254,
  parameter logic [7:0] SEL_RST = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    selreg_o
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == SEL_ADDR) ? SEL_RST : 8'h00;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o  = mem[raddr_i];
  assign selreg_o = mem[SEL_ADDR];
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int PAGE = 8,
  parameter int WR_CYCLES = 400,
  parameter int SEL_ADDR = 254
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] pin_sel_i,
  output logic       sda_oe_o
);
  localparam int PW = $clog2(PAGE + 1);
  localparam int IW = $clog2(PAGE);
  localparam int BW = $clog2(WR_CYCLES + 1);

  // Synchronized lines and bus events
  logic [2:0] lvl, rise, fall;
  twi_line_sync #(.N(3)) i_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({wp_i, sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );
  logic scl_lvl, sda_lvl, wp_lvl, ev_rise, ev_fall, ev_start, ev_stop;
  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign wp_lvl   = lvl[2];
  assign ev_rise  = rise[0];
  assign ev_fall  = fall[0];
  assign ev_start = fall[1] & scl_lvl;
  assign ev_stop  = rise[1] & scl_lvl;

  // Byte engine state
  phase_t        phase;
  logic [3:0]    bit_cnt;
  logic          ack_slot, rw, mack, sda_oe_q;
  logic [7:0]    shreg, txbyte, ptr, wbase;
  logic [7:0]    pbuf [PAGE];
  logic [PW-1:0] pend_cnt, commit_n, wr_idx;
  logic [BW-1:0] busy_cnt;

  // Memory
  logic       we, busy;
  logic [7:0] rd_byte, selreg;
  assign busy = (busy_cnt != '0);
  assign we   = busy && (wr_idx < commit_n);

  twi_regfile #(.AW(8), .SEL_ADDR(SEL_ADDR), .SEL_RST(8'h01)) i_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we),
    .waddr_i(wbase + 8'(wr_idx)), .wdata_i(pbuf[wr_idx[IW-1:0]]),
    .raddr_i(ptr), .rdata_o(rd_byte), .selreg_o(selreg)
  );

  // Named decision points
  logic byte_done, dev_done, dev_hit, data_take, commit_go, rd_advance;
  assign byte_done  = ev_fall && !ack_slot && (bit_cnt == 4'd8);
  assign dev_done   = byte_done && (phase == PH_DEV);
  assign dev_hit    = dev_done && ctrl_hit(shreg, eff_select(pin_sel_i, selreg)) && !busy;
  assign data_take  = byte_done && (phase == PH_WDATA) && !wp_lvl && (pend_cnt < PW'(PAGE));
  assign commit_go  = ev_stop && (pend_cnt != '0) && !busy;
  assign rd_advance = (phase == PH_RD) && byte_done;

  always_ff @(posedge clk) begin
    if (data_take) pbuf[pend_cnt[IW-1:0]] <= shreg;
  end

  // Commit engine: one buffered byte per clock inside the write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      commit_n <= '0;
      wr_idx   <= '0;
    end else if (commit_go) begin
      busy_cnt <= BW'(WR_CYCLES);
      commit_n <= pend_cnt;
      wr_idx   <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - BW'(1);
      if (we) wr_idx <= wr_idx + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bit_cnt <= '0; ack_slot <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sda_oe_q <= 1'b0; shreg <= '0; txbyte <= '0; ptr <= '0; wbase <= '0; pend_cnt <= '0;
    end else if (ev_start) begin
      phase <= PH_DEV; bit_cnt <= '0; ack_slot <= 1'b0; sda_oe_q <= 1'b0; pend_cnt <= '0;
    end else if (ev_stop) begin
      phase <= PH_IDLE; ack_slot <= 1'b0; sda_oe_q <= 1'b0; pend_cnt <= '0;
    end else begin
      case (phase)
        PH_DEV, PH_MADDR, PH_WDATA: begin
          if (!ack_slot) begin
            if (ev_rise) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              if (phase == PH_DEV) begin
                if (dev_hit) begin
                  sda_oe_q <= 1'b1; ack_slot <= 1'b1; rw <= shreg[0];
                end else phase <= PH_SKIP;
              end else if (phase == PH_MADDR) begin
                ptr <= shreg; wbase <= shreg; sda_oe_q <= 1'b1; ack_slot <= 1'b1;
              end else if (data_take) begin
                pend_cnt <= pend_cnt + PW'(1); ptr <= ptr + 8'd1;
                sda_oe_q <= 1'b1; ack_slot <= 1'b1;
              end else phase <= PH_SKIP;
            end
          end else if (ev_fall) begin
            ack_slot <= 1'b0; bit_cnt <= '0; sda_oe_q <= 1'b0;
            if (phase == PH_DEV) begin
              if (rw) begin
                phase <= PH_RD; txbyte <= rd_byte; sda_oe_q <= tx_pull(rd_byte, 4'd0);
              end else phase <= PH_MADDR;
            end else if (phase == PH_MADDR) phase <= PH_WDATA;
          end
        end
        PH_RD: begin
          if (!ack_slot) begin
            if (ev_rise) bit_cnt <= bit_cnt + 4'd1;
            else if (rd_advance) begin
              sda_oe_q <= 1'b0; ack_slot <= 1'b1; ptr <= ptr + 8'd1;
            end else if (ev_fall) sda_oe_q <= tx_pull(txbyte, bit_cnt);
          end else begin
            if (ev_rise) mack <= !sda_lvl;
            else if (ev_fall) begin
              ack_slot <= 1'b0; bit_cnt <= '0;
              if (mack) begin
                txbyte <= rd_byte; sda_oe_q <= tx_pull(rd_byte, 4'd0);
              end else phase <= PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  // Assertions
  assert_pull_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !scl_lvl);
  assert_skip_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_oe_q);
  assert_busy_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> !sda_oe_q);
  assert_page_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PAGE));
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == $past(pend_cnt) + PW'(1)) |-> !$past(wp_lvl));
  assert_ptr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_advance |=> (ptr == $past(ptr) + 8'd1));
  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RD) && ack_slot && ev_fall && !mack) |=> !sda_oe_q);
endmodule

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int WRC = 400;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b000;
  logic sda_oe, sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twi_mem_slave #(.PAGE(8), .WR_CYCLES(WRC), .SEL_ADDR(254)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wp_i(wp),
    .pin_sel_i(pins), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'h00;
  logic [2:0] cur_sel = 3'b000;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic gap(); repeat (H) @(negedge clk); endtask
  task automatic settle(); repeat (WRC + 20) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; gap(); scl = 1'b1; gap(); sda_m = 1'b0; gap(); scl = 1'b0; gap();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; gap(); scl = 1'b1; gap(); sda_m = 1'b1; gap();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; gap(); scl = 1'b1; gap(); gap(); scl = 1'b0; gap();
    end
    sda_m = 1'b1; gap(); scl = 1'b1; gap(); ack = !sda_bus; gap(); scl = 1'b0; gap();
  endtask

  task automatic recv_byte(input logic mst_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; gap(); scl = 1'b1; gap(); b[i] = sda_bus; gap(); scl = 1'b0; gap();
    end
    sda_m = !mst_ack; gap(); scl = 1'b1; gap(); gap(); scl = 1'b0; gap();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      exp_q.push_back(ref_mem[ref_ptr]);
      tag_q.push_back(tag);
      got_q.push_back(b);
      ref_ptr = ref_ptr + 8'd1;
    end
    chk(sda_oe == 1'b0, {tag, " R9 release after nack"}, sda_oe, 0);
  endtask

  task automatic probe(input logic [2:0] sel, input logic exp_ack, input string tag);
    logic a;
    bus_start();
    send_byte(ctrl(sel, 1'b0), a);
    chk(a == exp_ack, tag, a, exp_ack);
    bus_stop();
  endtask

  task automatic write_txn(input logic [7:0] addr, input int n, input logic [7:0] v0,
                           input bit do_stop, input string tag);
    logic a;
    int acc;
    acc = 0;
    bus_start();
    send_byte(ctrl(cur_sel, 1'b0), a);
    chk(a == 1'b1, {tag, " R2 control ack"}, a, 1);
    send_byte(addr, a);
    chk(a == 1'b1, {tag, " R2 address ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      logic exp_a;
      exp_a = !wp && (i < 8);
      send_byte(v0 + 8'(i), a);
      chk(a == exp_a, {tag, " R3 R8 data ack"}, a, exp_a);
      if (a) acc++;
    end
    ref_ptr = addr + 8'(acc);
    if (do_stop) begin
      bus_stop();
      for (int j = 0; j < acc; j++) ref_mem[addr + 8'(j)] = v0 + 8'(j);
    end
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string tag);
    logic a;
    bus_start();
    send_byte(ctrl(cur_sel, 1'b0), a);
    chk(a == 1'b1, {tag, " R6 dummy write ack"}, a, 1);
    send_byte(addr, a);
    chk(a == 1'b1, {tag, " R6 address ack"}, a, 1);
    bus_start();
    send_byte(ctrl(cur_sel, 1'b1), a);
    chk(a == 1'b1, {tag, " R6 read control ack"}, a, 1);
    ref_ptr = addr;
    rd_bytes(n, tag);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string tag);
    logic a;
    bus_start();
    send_byte(ctrl(cur_sel, 1'b1), a);
    chk(a == 1'b1, {tag, " R5 read control ack"}, a, 1);
    rd_bytes(n, tag);
    bus_stop();
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() != 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", g, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g === e, t, g, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    for (int i = 0; i < 256; i++) ref_mem[i] = (i == 254) ? 8'h01 : 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 data line released after reset", sda_oe, 0);
    cur_read(1, "R11 reset pointer and contents");
    rand_read(8'hFE, 1, "R10 R11 select register default");

    // Byte write, acknowledge polling
    write_txn(8'h10, 1, 8'hA5, 1'b1, "R4 byte write");
    probe(cur_sel, 1'b0, "R4 control refused during write cycle");
    settle();
    probe(cur_sel, 1'b1, "R4 control accepted after write cycle");
    rand_read(8'h10, 1, "R6 random read");
    cur_read(1, "R5 current address read");

    // Page write and sequential read
    write_txn(8'h20, 8, 8'h30, 1'b1, "R3 page write");
    settle();
    rand_read(8'h20, 8, "R9 sequential readback");
    write_txn(8'h40, 9, 8'h60, 1'b1, "R3 ninth byte");
    settle();
    rand_read(8'h40, 9, "R3 page limit readback");

    // Abandoned write
    write_txn(8'h50, 1, 8'h77, 1'b0, "R7 no stop");
    rand_read(8'h50, 1, "R7 repeated start discards");
    settle();
    rand_read(8'h50, 1, "R7 still unwritten");

    // Address mismatches
    bus_start();
    send_byte(ctrl(3'b011, 1'b0), a);
    chk(a == 1'b0, "R1 wrong select refused", a, 0);
    send_byte(8'h00, a);
    chk(a == 1'b0, "R1 silent after mismatch", a, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, 3'b000, 1'b0}, a);
    chk(a == 1'b0, "R1 wrong code refused", a, 0);
    bus_stop();
    probe(3'b000, 1'b1, "R1 matching control accepted");

    // Pointer wrap
    write_txn(8'hFF, 1, 8'h5A, 1'b1, "R5 last location write");
    settle();
    rand_read(8'hFF, 2, "R5 wrap in sequential read");
    cur_read(1, "R5 pointer after wrap");

    // Write protect
    wp = 1'b1;
    write_txn(8'h60, 1, 8'h99, 1'b1, "R8 protected write");
    settle();
    wp = 1'b0;
    rand_read(8'h60, 1, "R8 memory unchanged");

    // Select register
    write_txn(8'hFE, 1, 8'h0A, 1'b1, "R10 select write");
    settle();
    probe(3'b000, 1'b0, "R10 old select refused");
    probe(3'b101, 1'b1, "R10 internal select accepted");
    cur_sel = 3'b101;
    rand_read(8'hFE, 1, "R10 select readback");
    pins = 3'b010;
    repeat (5) @(negedge clk);
    probe(3'b101, 1'b0, "R10 nonzero pins override register");
    probe(3'b010, 1'b1, "R10 pin select accepted");
    pins = 3'b000;
    repeat (5) @(negedge clk);
    write_txn(8'hFE, 1, 8'h01, 1'b1, "R10 select restore");
    settle();
    cur_sel = 3'b000;
    probe(3'b000, 1'b1, "R10 pins in force after restore");

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule